// File: doc/BRIEF.md
# Speculation-Aware Cache Set Controller

This block keeps the per-way metadata of one set in a set-associative first-level data cache. For each fill it picks the way to replace. It also decides what happens to the displaced line on its way to the second-level cache. Every line records four things: whether it came in on a wrong path or from the prefetcher, whether a correct-path access has since used it, its branch tag, and whether that branch is still unresolved. A full recency order across the ways is updated on every hit and every fill.

Fills arrive on a valid/ready port and are tagged correct-path, wrong-path or prefetch. Hit notifications name a way and say whether the access was speculative. Branch-resolution notifications carry a tag and either confirm or squash. The controller replaces invalid ways first. Next it prefers lines still marked wrong-path, and only then falls back to plain least-recently-used order.

When a valid line is displaced, the block emits a one-cycle pulse with the way index and a forwarding code. A line that arrived speculatively and was never touched by a correct-path access is either dropped or sent at low priority, as a configuration pin selects. Every other line is installed normally. The decision uses the line's resolved status, including any resolution or hit that lands in the same cycle as the fill. Data arrays, tag compare, coherence and the second-level cache live outside this block.

Top module: `spec_set_ctrl`

## Requirements
- R1: After reset all ways are invalid and no pulse is emitted. The first four fills land in ways 0, 1, 2 and 3 in that order, with no eviction pulse.
- R2: A fill is taken in each cycle where fill_valid and fill_ready are both high. fill_ready is low during reset and stays high from the first clock edge after reset release, so the port never applies back-pressure. One cycle after a fill is taken, place_valid pulses with the chosen way on place_way.
- R3: If any way is invalid, the lowest-numbered invalid way is chosen.
- R4: If every way is valid and none is marked wrong-path, the least-recently-used way is chosen. Recency is updated by every hit to a valid way, speculative or not, and by every fill; the touched way becomes most recent.
- R5: If every way is valid and some are marked wrong-path, the victim is the least recently used among the wrong-path ways.
- R6: A non-speculative hit sets the line's used flag and removes its wrong-path mark, so the line is no longer preferred as victim and is installed when evicted.
- R7: A confirm resolution clears the wrong-path mark of a still-pending line whose stored tag matches. A squash ends the pending state and leaves the mark, so a later confirm with the same tag has no effect.
- R8: When the victim was valid, evict_valid pulses in the same cycle as place_valid, with evict_way equal to the victim. evict_code is 0 (install) for a line that is correct-path or used. For a line that is unused and either wrong-path or prefetched, it is 2 (drop) when cfg_drop was high in the fill cycle and 1 (low priority) otherwise.
- R9: Fill kind encoding is 0 correct-path, 1 wrong-path, 2 prefetch. A prefetched line gets no victim preference, but it is filtered like a wrong-path line when evicted unused.
- R10: When a fill meets a hit or a resolution in the same cycle, the victim is chosen from the state before that cycle. The forwarding code reflects that cycle's hit or resolution on the victim. Recency applies the hit first and the fill second.
- R11: A speculative hit updates recency only. It neither sets the used flag nor clears the wrong-path mark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_drop | input | 1 | 1: drop unused speculative victims, 0: send them at low priority |
| fill_valid | input | 1 | Fill request present |
| fill_ready | output | 1 | Fill accepted this cycle when high |
| fill_kind | input | 2 | 0 correct-path, 1 wrong-path, 2 prefetch |
| fill_btag | input | BTW | Branch tag of a wrong-path fill |
| hit_valid | input | 1 | Hit notification present |
| hit_way | input | IW | Way that was hit |
| hit_spec | input | 1 | Hit came from a speculative access |
| res_valid | input | 1 | Branch resolution present |
| res_btag | input | BTW | Tag being resolved |
| res_squash | input | 1 | 1 squash, 0 confirm |
| place_valid | output | 1 | Pulse: a fill was placed |
| place_way | output | IW | Way that received the fill |
| evict_valid | output | 1 | Pulse: a valid line was displaced |
| evict_way | output | IW | Way of the displaced line |
| evict_code | output | 2 | 0 install, 1 low-priority install, 2 drop |

## Verification
The overlaps of interest are a fill arriving together with a non-speculative hit, and a fill arriving together with a branch confirm. In both cases the victim follows the state from before that cycle, while the forwarding code takes the new information into account. The bench drives these pairs in the same cycle: a confirm for the wrong-path line about to be evicted, a correct-path hit on that line, and a hit on the least-recent way. It then judges the way and code the scoreboard predicted. A following fill shows whether recency was updated in hit-then-fill order.

// File: rtl/scs_pkg.sv
package scs_pkg;

  typedef enum logic [1:0] {
    FK_CORRECT  = 2'd0,
    FK_WRONG    = 2'd1,
    FK_PREFETCH = 2'd2
  } fill_kind_e;

  typedef enum logic [1:0] {
    EV_INSTALL = 2'd0,
    EV_LOWPRI  = 2'd1,
    EV_DROP    = 2'd2
  } ev_code_e;

  // Per-way metadata flags
  typedef struct packed {
    logic valid;  // line present
    logic wp;     // marked wrong-path (victim preference)
    logic pfo;    // brought in by the prefetcher
    logic used;   // referenced by a correct-path access
    logic pend;   // waiting for its branch to resolve
  } way_flags_t;

endpackage

// File: rtl/scs_lru.sv
module scs_lru #(
  parameter int WAYS = 4,
  parameter int IW   = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      hit_touch,
  input  logic [IW-1:0]             hit_way,
  input  logic                      fill_touch,
  input  logic [IW-1:0]             fill_way,
  output logic [WAYS-1:0][IW-1:0]   age_o
);

  logic [WAYS-1:0][IW-1:0] age_q, age_h, age_d;

  // Move way w to age 0; every younger way ages by one.
  function automatic logic [WAYS-1:0][IW-1:0] touch(
    input logic [WAYS-1:0][IW-1:0] a,
    input logic [IW-1:0]           w
  );
    logic [WAYS-1:0][IW-1:0] r;
    logic [IW-1:0]           pivot;
    pivot = a[w];
    for (int i = 0; i < WAYS; i++) begin
      if (IW'(i) == w)       r[i] = '0;
      else if (a[i] < pivot) r[i] = a[i] + 1'b1;
      else                   r[i] = a[i];
    end
    return r;
  endfunction

  always_comb begin
    age_h = hit_touch  ? touch(age_q, hit_way)  : age_q;
    age_d = fill_touch ? touch(age_h, fill_way) : age_h;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WAYS; i++) age_q[i] <= IW'(i);
    end else begin
      age_q <= age_d;
    end
  end

  assign age_o = age_q;

endmodule

// File: rtl/scs_meta.sv
module scs_meta
  import scs_pkg::*;
#(
  parameter int WAYS = 4,
  parameter int IW   = 2,
  parameter int BTW  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    hit_valid,
  input  logic [IW-1:0]           hit_way,
  input  logic                    hit_spec,
  input  logic                    res_valid,
  input  logic [BTW-1:0]          res_btag,
  input  logic                    res_squash,
  input  logic                    fill_fire,
  input  logic [IW-1:0]           fill_way,
  input  logic [1:0]              fill_kind,
  input  logic [BTW-1:0]          fill_btag,
  output way_flags_t [WAYS-1:0]   flags_q,
  output way_flags_t [WAYS-1:0]   flags_upd
);

  logic [WAYS-1:0][BTW-1:0] btag_q;

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    way_flags_t nxt;
    way_flags_t ins;

    // Effect of this cycle's resolution and hit on the resident line
    always_comb begin
      nxt = flags_q[g];
      if (res_valid && nxt.valid && nxt.pend && (btag_q[g] == res_btag)) begin
        nxt.pend = 1'b0;
        if (!res_squash) nxt.wp = 1'b0;
      end
      if (hit_valid && !hit_spec && nxt.valid && (hit_way == IW'(g))) begin
        nxt.used = 1'b1;
        nxt.wp   = 1'b0;
        nxt.pend = 1'b0;
      end
    end

    // Metadata of a line arriving by fill
    always_comb begin
      ins.valid = 1'b1;
      ins.wp    = (fill_kind == FK_WRONG);
      ins.pfo   = (fill_kind == FK_PREFETCH);
      ins.used  = 1'b0;
      ins.pend  = (fill_kind == FK_WRONG);
    end

    assign flags_upd[g] = nxt;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        flags_q[g] <= '0;
        btag_q[g]  <= '0;
      end else if (fill_fire && (fill_way == IW'(g))) begin
        flags_q[g] <= ins;
        btag_q[g]  <= fill_btag;
      end else begin
        flags_q[g] <= nxt;
      end
    end
  end

endmodule

// File: rtl/scs_victim.sv
module scs_victim
  import scs_pkg::*;
#(
  parameter int WAYS = 4,
  parameter int IW   = 2
) (
  input  way_flags_t [WAYS-1:0]    flags,
  input  logic [WAYS-1:0][IW-1:0]  ages,
  output logic [IW-1:0]            victim
);

  logic          inv_any, wp_any;
  logic [IW-1:0] inv_w, wp_w, wp_age, lru_w, lru_age;

  always_comb begin
    // lowest-numbered invalid way
    inv_any = 1'b0;
    inv_w   = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!flags[i].valid) begin
        inv_any = 1'b1;
        inv_w   = IW'(i);
      end
    end
    // oldest wrong-path way and oldest way overall
    wp_any  = 1'b0;
    wp_w    = '0;
    wp_age  = '0;
    lru_w   = '0;
    lru_age = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (flags[i].valid && flags[i].wp && (!wp_any || ages[i] > wp_age)) begin
        wp_any = 1'b1;
        wp_w   = IW'(i);
        wp_age = ages[i];
      end
      if (ages[i] >= lru_age) begin
        lru_w   = IW'(i);
        lru_age = ages[i];
      end
    end
    if (inv_any)     victim = inv_w;
    else if (wp_any) victim = wp_w;
    else             victim = lru_w;
  end

endmodule

// File: rtl/spec_set_ctrl.sv
module spec_set_ctrl
  import scs_pkg::*;
#(
  parameter int  WAYS = 4,
  parameter int  BTW  = 4,
  localparam int IW   = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_drop,
  input  logic            fill_valid,
  output logic            fill_ready,
  input  logic [1:0]      fill_kind,
  input  logic [BTW-1:0]  fill_btag,
  input  logic            hit_valid,
  input  logic [IW-1:0]   hit_way,
  input  logic            hit_spec,
  input  logic            res_valid,
  input  logic [BTW-1:0]  res_btag,
  input  logic            res_squash,
  output logic            place_valid,
  output logic [IW-1:0]   place_way,
  output logic            evict_valid,
  output logic [IW-1:0]   evict_way,
  output logic [1:0]      evict_code
);

  way_flags_t [WAYS-1:0]    flags_q, flags_upd;
  logic [WAYS-1:0][IW-1:0]  ages;
  logic [IW-1:0]            victim;
  logic                     rdy_q, fill_fire, hit_touch;
  way_flags_t               vic_now;
  ev_code_e                 code_d;

  assign fill_ready = rdy_q;
  assign fill_fire  = fill_valid && rdy_q;
  assign hit_touch  = hit_valid && flags_q[hit_way].valid;

  scs_meta #(.WAYS(WAYS), .IW(IW), .BTW(BTW)) u_meta (
    .clk        (clk),
    .rst_n      (rst_n),
    .hit_valid  (hit_valid),
    .hit_way    (hit_way),
    .hit_spec   (hit_spec),
    .res_valid  (res_valid),
    .res_btag   (res_btag),
    .res_squash (res_squash),
    .fill_fire  (fill_fire),
    .fill_way   (victim),
    .fill_kind  (fill_kind),
    .fill_btag  (fill_btag),
    .flags_q    (flags_q),
    .flags_upd  (flags_upd)
  );

  scs_lru #(.WAYS(WAYS), .IW(IW)) u_lru (
    .clk        (clk),
    .rst_n      (rst_n),
    .hit_touch  (hit_touch),
    .hit_way    (hit_way),
    .fill_touch (fill_fire),
    .fill_way   (victim),
    .age_o      (ages)
  );

  scs_victim #(.WAYS(WAYS), .IW(IW)) u_vic (
    .flags  (flags_q),
    .ages   (ages),
    .victim (victim)
  );

  // Forwarding decision from the victim's status after this cycle's events
  always_comb begin
    vic_now = flags_upd[victim];
    if (!vic_now.used && (vic_now.wp || vic_now.pfo))
      code_d = cfg_drop ? EV_DROP : EV_LOWPRI;
    else
      code_d = EV_INSTALL;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy_q       <= 1'b0;
      place_valid <= 1'b0;
      place_way   <= '0;
      evict_valid <= 1'b0;
      evict_way   <= '0;
      evict_code  <= 2'd0;
    end else begin
      rdy_q       <= 1'b1;
      place_valid <= fill_fire;
      evict_valid <= fill_fire && flags_q[victim].valid;
      if (fill_fire) begin
        place_way  <= victim;
        evict_way  <= victim;
        evict_code <= code_d;
      end
    end
  end

endmodule

// File: rtl/spec_set_ctrl_chk.sv
module spec_set_ctrl_chk #(
  parameter int WAYS = 4,
  parameter int BTW  = 4,
  parameter int IW   = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_drop,
  input logic          fill_valid,
  input logic          fill_ready,
  input logic          place_valid,
  input logic [IW-1:0] place_way,
  input logic          evict_valid,
  input logic [IW-1:0] evict_way,
  input logic [1:0]    evict_code
);

  p_ready_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> fill_ready);

  p_place_follows_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && fill_ready) |=> place_valid);

  p_no_spurious_place_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill_valid && fill_ready) |=> !place_valid);

  p_way_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    place_valid |-> (int'(place_way) < WAYS));

  p_evict_with_place_r8: assert property (@(posedge clk) disable iff (!rst_n)
    evict_valid |-> (place_valid && evict_way == place_way));

  p_code_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    evict_valid |-> (evict_code != 2'd3));

  p_drop_needs_cfg_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (evict_valid && evict_code == 2'd2) |-> $past(cfg_drop));

  p_lowpri_needs_cfg_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (evict_valid && evict_code == 2'd1) |-> !$past(cfg_drop));

endmodule

bind spec_set_ctrl spec_set_ctrl_chk #(.WAYS(WAYS), .BTW(BTW), .IW(IW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_drop    (cfg_drop),
  .fill_valid  (fill_valid),
  .fill_ready  (fill_ready),
  .place_valid (place_valid),
  .place_way   (place_way),
  .evict_valid (evict_valid),
  .evict_way   (evict_way),
  .evict_code  (evict_code)
);

// File: tb/sim_spec_set_ctrl.sv
module sim_spec_set_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int WAYS = 4;
  localparam int BTW  = 4;
  localparam int IW   = 2;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           cfg_drop = 1'b0;
  logic           fill_valid = 1'b0;
  logic           fill_ready;
  logic [1:0]     fill_kind = 2'd0;
  logic [BTW-1:0] fill_btag = '0;
  logic           hit_valid = 1'b0;
  logic [IW-1:0]  hit_way = '0;
  logic           hit_spec = 1'b0;
  logic           res_valid = 1'b0;
  logic [BTW-1:0] res_btag = '0;
  logic           res_squash = 1'b0;
  logic           place_valid;
  logic [IW-1:0]  place_way;
  logic           evict_valid;
  logic [IW-1:0]  evict_way;
  logic [1:0]     evict_code;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  typedef struct {
    int    way;
    bit    ev;
    int    code;
    string req;
  } exp_t;

  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  spec_set_ctrl #(.WAYS(WAYS), .BTW(BTW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_drop(cfg_drop),
    .fill_valid(fill_valid), .fill_ready(fill_ready),
    .fill_kind(fill_kind), .fill_btag(fill_btag),
    .hit_valid(hit_valid), .hit_way(hit_way), .hit_spec(hit_spec),
    .res_valid(res_valid), .res_btag(res_btag), .res_squash(res_squash),
    .place_valid(place_valid), .place_way(place_way),
    .evict_valid(evict_valid), .evict_way(evict_way), .evict_code(evict_code)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Monitor: pop the scoreboard on every placement
  always @(negedge clk) begin
    if (rst_n && place_valid) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R2", "unexpected place", int'(place_way), -1);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(int'(place_way) == e.way, e.req, "place_way", int'(place_way), e.way);
        chk(evict_valid == e.ev, e.req, "evict_valid", int'(evict_valid), int'(e.ev));
        if (e.ev) begin
          chk(int'(evict_way) == e.way, e.req, "evict_way", int'(evict_way), e.way);
          chk(int'(evict_code) == e.code, e.req, "evict_code", int'(evict_code), e.code);
        end
      end
    end else if (rst_n && evict_valid) begin
      chk(1'b0, "R8", "evict without place", 1, 0);
    end
  end

  // One cycle of stimulus, aligned to a falling edge
  task automatic step(input bit f, input int k, input int bt,
                      input bit h, input int hw, input bit hs,
                      input bit r, input int rt, input bit sq,
                      input int ew, input bit eev, input int ec, input string req);
    fill_valid = f;  fill_kind = 2'(k); fill_btag = BTW'(bt);
    hit_valid  = h;  hit_way   = IW'(hw); hit_spec = hs;
    res_valid  = r;  res_btag  = BTW'(rt); res_squash = sq;
    if (f) begin
      exp_t e;
      e.way = ew; e.ev = eev; e.code = ec; e.req = req;
      sb.push_back(e);
    end
    @(negedge clk);
    fill_valid = 1'b0; hit_valid = 1'b0; res_valid = 1'b0;
  endtask

  task automatic fill(input int k, input int bt, input int ew, input bit eev, input int ec, input string req);
    step(1, k, bt, 0, 0, 0, 0, 0, 0, ew, eev, ec, req);
  endtask

  task automatic hit(input int hw, input bit hs);
    step(0, 0, 0, 1, hw, hs, 0, 0, 0, 0, 0, 0, "");
  endtask

  task automatic resolve(input int rt, input bit sq);
    step(0, 0, 0, 0, 0, 0, 1, rt, sq, 0, 0, 0, "");
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(place_valid == 1'b0, "R1", "place_valid in reset", int'(place_valid), 0);
    chk(evict_valid == 1'b0, "R1", "evict_valid in reset", int'(evict_valid), 0);
    chk(fill_ready == 1'b0, "R2", "fill_ready in reset", int'(fill_ready), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(fill_ready == 1'b1, "R2", "fill_ready after reset", int'(fill_ready), 1);
  endtask

  // kinds: 0 correct, 1 wrong-path, 2 prefetch; codes: 0 install, 1 low, 2 drop
  initial begin
    do_reset();

    // Phase A: cfg_drop low
    cfg_drop = 1'b0;
    fill(0, 0, 0, 0, 0, "R1");
    fill(0, 0, 1, 0, 0, "R1");
    fill(1, 1, 2, 0, 0, "R3");
    fill(0, 0, 3, 0, 0, "R3");
    fill(0, 0, 2, 1, 1, "R5");   // wrong-path way2 preferred, low priority
    fill(0, 0, 0, 1, 0, "R4");   // plain LRU
    hit(1, 1);                   // speculative hit only moves recency
    fill(0, 0, 3, 1, 0, "R4");   // LRU is way3 after hit on way1

    // Phase B: cfg_drop high, used flag and prefetch
    do_reset();
    cfg_drop = 1'b1;
    fill(0, 0, 0, 0, 0, "R1");
    fill(2, 0, 1, 0, 0, "R1");
    fill(1, 1, 2, 0, 0, "R1");
    fill(1, 2, 3, 0, 0, "R1");
    hit(2, 0);                   // correct-path use of way2
    hit(3, 1);                   // way3 most recent
    fill(0, 0, 3, 1, 2, "R6");   // way2 no longer wrong-path
    fill(0, 0, 0, 1, 0, "R9");   // prefetch way1 not preferred
    fill(0, 0, 1, 1, 2, "R9");   // unused prefetch dropped
    fill(0, 0, 2, 1, 0, "R6");   // used line installed

    // Phase C: LRU among wrong-path lines, confirm and squash
    do_reset();
    cfg_drop = 1'b0;
    fill(1, 1, 0, 0, 0, "R3");
    fill(1, 2, 1, 0, 0, "R3");
    fill(1, 3, 2, 0, 0, "R3");
    fill(0, 0, 3, 0, 0, "R3");
    hit(0, 1);
    fill(0, 0, 1, 1, 1, "R5");   // oldest wrong-path line
    resolve(3, 0);               // confirm way2
    fill(0, 0, 0, 1, 1, "R11");  // spec hit left way0 unused and wrong-path
    fill(0, 0, 2, 1, 0, "R7");   // confirmed line installed by LRU
    fill(1, 4, 3, 1, 0, "R4");
    resolve(4, 1);               // squash
    resolve(4, 0);               // late confirm ignored
    fill(0, 0, 3, 1, 1, "R7");

    // Phase D: same-cycle fill with resolution or hit
    do_reset();
    cfg_drop = 1'b1;
    fill(1, 5, 0, 0, 0, "R1");
    fill(0, 0, 1, 0, 0, "R1");
    fill(0, 0, 2, 0, 0, "R1");
    fill(0, 0, 3, 0, 0, "R1");
    step(1, 0, 0, 0, 0, 0, 1, 5, 0, 0, 1, 0, "R10");  // confirm with fill
    fill(1, 6, 1, 1, 0, "R4");
    step(1, 0, 0, 1, 1, 0, 0, 0, 0, 1, 1, 0, "R10");  // hit on victim with fill
    step(1, 0, 0, 1, 2, 0, 0, 0, 0, 2, 1, 0, "R10");  // hit on LRU way with fill
    fill(0, 0, 3, 1, 0, "R10");  // recency hit-then-fill order

    repeat (3) @(negedge clk);
    chk(sb.size() == 0, "R2", "scoreboard drained", sb.size(), 0);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL R2 watchdog: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule